// File: doc/BRIEF.md
# Segment Address Translator with Hidden Descriptor Cache

This block turns a segment register number and a 32-bit effective offset into a 32-bit linear address. It holds six segment registers. Each one has a visible 16-bit selector and a hidden cache entry with a base, an effective limit and a 12-bit rights field. A requester writes a selector through the load port. In protected mode the requester also supplies the 64-bit descriptor it has already fetched. The block unpacks that descriptor, checks that it suits the target register and, if the load is legal, refreshes the whole cache entry in one cycle. In real mode the entry is built from the selector alone, and the descriptor input is ignored.

Accesses go through a separate port. In real mode the address is the selector shifted left by four plus the offset, and the limit is fixed at 64 KiB. In protected mode the address is the cached base plus the offset, and the access is checked against the cached limit. The block flags illegal loads, loads of absent segments and limit violations. It also reports the selector and rights of the register that was accessed, so that later stages can compare privilege levels.

Segment register indices: ES=0, CS=1, SS=2, DS=3, FS=4, GS=5; indices 6 and 7 do not exist. `acc_size_i` holds the access size in bytes minus one (0 to 3). The rights layout is [0] accessed, [1] readable/writable, [2] conforming/expand-down, [3] executable, [4] code/data (S), [6:5] DPL, [7] present, [8] available, [9] reserved, [10] default size, [11] granularity.

Top module: `seg_xlate`

## Requirements
- R1: After reset, every register holds selector 0, base 0, limit 0xFFFF and rights 0x092, and all response outputs are low.
- R2: In real mode, a load to any index from 0 to 5 is accepted with any selector (ld_ok_o high), whatever the descriptor input holds. The entry becomes base = selector*16, limit = 0xFFFF and rights = 0x092.
- R3: A real-mode access to register n gives lin_addr_o = selector_n*16 + offset. It raises lim_fault_o instead of acc_valid_o when offset + acc_size_i exceeds 0xFFFF.
- R4: A protected-mode access gives lin_addr_o = cached base + offset, modulo 2^32. The base is built from descriptor bits 63:56, 39:32 and 31:16.
- R5: The protected limit is the 20-bit value {desc[51:48], desc[15:0]}. When G (desc[55]) is 0 it is used as bytes. When G is 1 it is shifted left by 12 with the low 12 bits set to ones. An access with offset + acc_size_i > limit, computed without wraparound, raises lim_fault_o and gives no acc_valid_o. Exactly one of the two outputs answers each access.
- R6: In protected mode, a load to CS of a descriptor with X (desc[43]) = 0 raises ld_type_fault_o.
- R7: In protected mode, a load to SS of a descriptor with X = 1 raises ld_type_fault_o.
- R8: In protected mode, a load of a descriptor with S (desc[44]) = 0 raises ld_type_fault_o for any register.
- R9: In protected mode, a load that is type-legal but has P (desc[47]) = 0 raises ld_np_fault_o. A type fault takes priority over a not-present fault.
- R10: A faulting load leaves the target's selector and cache unchanged. A load to index 6 or 7 raises ld_type_fault_o, and an access to index 6 or 7 raises lim_fault_o.
- R11: A granted access also returns the register's visible selector on acc_sel_o and its cached rights on acc_rights_o. In protected mode those rights are {desc[55:52], desc[47:40]}.
- R12: An access in the same cycle as a load to the same register sees the contents from before the load. The new contents apply from the next cycle.
- R13: Every load and access response appears exactly one cycle after its request. The strobes are low in any cycle that follows a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prot_mode_i | input | 1 | 1 = protected mode, 0 = real mode |
| ld_valid_i | input | 1 | Selector load request |
| ld_seg_i | input | 3 | Target register index |
| ld_sel_i | input | 16 | New selector value |
| ld_desc_i | input | 64 | Descriptor for the selector (protected mode only) |
| acc_valid_i | input | 1 | Access request |
| acc_seg_i | input | 3 | Register index used by the access |
| acc_off_i | input | 32 | Effective offset |
| acc_size_i | input | 2 | Access bytes minus one |
| ld_ok_o | output | 1 | Load accepted, cache refreshed |
| ld_type_fault_o | output | 1 | Load rejected: descriptor unsuited to target |
| ld_np_fault_o | output | 1 | Load rejected: segment not present |
| acc_valid_o | output | 1 | Linear address valid |
| lim_fault_o | output | 1 | Access outside limit or to a missing register |
| lin_addr_o | output | 32 | Linear address |
| acc_sel_o | output | 16 | Selector of the accessed register |
| acc_rights_o | output | 12 | Cached rights of the accessed register |

## Verification
The hidden cache can be seen only through accesses. A corrupted base appears as a wrong lin_addr_o, and a corrupted limit appears as a wrong choice between acc_valid_o and lim_fault_o. Both show one cycle after the first access to the affected register. A load that updates the cache when it should not, or that fails to update it, stays hidden until that register is next accessed. The bench therefore follows every faulting load with an access to the same register, and keeps offsets close to the limit so that an off-by-one in the limit check changes the response.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned SEL_W    = 16;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned DESC_W   = 64;
  localparam int unsigned RIGHTS_W = 12;
  localparam int unsigned SIZE_W   = 2;
  localparam int unsigned LIM_W    = 20;
  localparam int unsigned PAGE_SH  = 12;

  localparam int unsigned SEG_CS = 1;
  localparam int unsigned SEG_SS = 2;

  // rights bit positions
  localparam int unsigned RT_X = 3;
  localparam int unsigned RT_S = 4;
  localparam int unsigned RT_P = 7;
  localparam int unsigned RT_G = 11;

  localparam logic [ADDR_W-1:0]   REAL_LIM    = ADDR_W'(32'h0000_FFFF);
  localparam logic [RIGHTS_W-1:0] REAL_RIGHTS = 12'h092;

  typedef struct packed {
    logic [SEL_W-1:0]    sel;
    logic [ADDR_W-1:0]   base;
    logic [ADDR_W-1:0]   lim;
    logic [RIGHTS_W-1:0] rights;
  } seg_entry_t;

  function automatic seg_entry_t reset_entry();
    seg_entry_t e;
    e.sel    = '0;
    e.base   = '0;
    e.lim    = REAL_LIM;
    e.rights = REAL_RIGHTS;
    return e;
  endfunction
endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_pkg::*;
(
  input  logic              prot_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DESC_W-1:0] desc_i,
  output seg_entry_t        entry_o
);
  logic [LIM_W-1:0]    lim_raw;
  logic [ADDR_W-1:0]   pm_base;
  logic [ADDR_W-1:0]   pm_lim;
  logic [RIGHTS_W-1:0] pm_rights;

  assign lim_raw   = {desc_i[51:48], desc_i[15:0]};
  assign pm_base   = {desc_i[63:56], desc_i[39:16]};
  assign pm_rights = {desc_i[55:52], desc_i[47:40]};

  // limit expanded once at load time, not on every access
  assign pm_lim = pm_rights[RT_G] ? {lim_raw, {PAGE_SH{1'b1}}}
                                  : ADDR_W'(lim_raw);

  always_comb begin
    entry_o.sel = sel_i;
    if (prot_i) begin
      entry_o.base   = pm_base;
      entry_o.lim    = pm_lim;
      entry_o.rights = pm_rights;
    end else begin
      entry_o.base   = ADDR_W'({sel_i, 4'b0000});
      entry_o.lim    = REAL_LIM;
      entry_o.rights = REAL_RIGHTS;
    end
  end
endmodule

// File: rtl/seg_load_check.sv
module seg_load_check
  import seg_pkg::*;
#(
  parameter int unsigned NUM_SEG = 6,
  parameter int unsigned IDX_W   = $clog2(NUM_SEG)
) (
  input  logic             prot_i,
  input  logic [IDX_W-1:0] seg_i,
  input  logic             exec_i,
  input  logic             code_data_i,
  input  logic             present_i,
  output logic             type_fault_o,
  output logic             np_fault_o
);
  logic bad_idx, bad_cs, bad_ss, bad_sys;

  assign bad_idx = int'(seg_i) >= NUM_SEG;
  assign bad_cs  = (seg_i == IDX_W'(SEG_CS)) && !exec_i;
  assign bad_ss  = (seg_i == IDX_W'(SEG_SS)) && exec_i;
  assign bad_sys = !code_data_i;

  assign type_fault_o = bad_idx || (prot_i && (bad_sys || bad_cs || bad_ss));
  assign np_fault_o   = prot_i && !type_fault_o && !present_i;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
(
  input  logic              prot_i,
  input  logic              seg_ok_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] lim_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fault_o
);
  logic [ADDR_W-1:0] base, lim;
  logic [ADDR_W:0]   last;

  // real mode path ignores the hidden cache
  always_comb begin
    if (prot_i) begin
      base = base_i;
      lim  = lim_i;
    end else begin
      base = ADDR_W'({sel_i, 4'b0000});
      lim  = REAL_LIM;
    end
  end

  assign last    = {1'b0, off_i} + (ADDR_W+1)'(size_i);
  assign fault_o = !seg_ok_i || (last > {1'b0, lim});
  assign addr_o  = base + off_i;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int unsigned NUM_SEG = 6,
  localparam int unsigned IDX_W  = $clog2(NUM_SEG)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                prot_mode_i,
  input  logic                ld_valid_i,
  input  logic [IDX_W-1:0]    ld_seg_i,
  input  logic [SEL_W-1:0]    ld_sel_i,
  input  logic [DESC_W-1:0]   ld_desc_i,
  input  logic                acc_valid_i,
  input  logic [IDX_W-1:0]    acc_seg_i,
  input  logic [ADDR_W-1:0]   acc_off_i,
  input  logic [SIZE_W-1:0]   acc_size_i,
  output logic                ld_ok_o,
  output logic                ld_type_fault_o,
  output logic                ld_np_fault_o,
  output logic                acc_valid_o,
  output logic                lim_fault_o,
  output logic [ADDR_W-1:0]   lin_addr_o,
  output logic [SEL_W-1:0]    acc_sel_o,
  output logic [RIGHTS_W-1:0] acc_rights_o
);
  seg_entry_t new_entry;
  seg_entry_t cache [NUM_SEG];
  seg_entry_t acc_entry;
  logic       type_fault, np_fault, ld_accept;
  logic       acc_seg_ok, acc_fault;
  logic [ADDR_W-1:0] acc_addr;

  seg_desc_unpack u_unpack (
    .prot_i  (prot_mode_i),
    .sel_i   (ld_sel_i),
    .desc_i  (ld_desc_i),
    .entry_o (new_entry)
  );

  seg_load_check #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_check (
    .prot_i       (prot_mode_i),
    .seg_i        (ld_seg_i),
    .exec_i       (new_entry.rights[RT_X]),
    .code_data_i  (new_entry.rights[RT_S]),
    .present_i    (new_entry.rights[RT_P]),
    .type_fault_o (type_fault),
    .np_fault_o   (np_fault)
  );

  assign ld_accept = ld_valid_i && !type_fault && !np_fault;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    seg_entry_t entry_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   entry_q <= reset_entry();
      else if (ld_accept && ld_seg_i == IDX_W'(g))   entry_q <= new_entry;
    end
    assign cache[g] = entry_q;
  end

  always_comb begin
    acc_entry  = reset_entry();
    acc_seg_ok = 1'b0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (acc_seg_i == IDX_W'(i)) begin
        acc_entry  = cache[i];
        acc_seg_ok = 1'b1;
      end
    end
  end

  seg_addr_gen u_addr (
    .prot_i   (prot_mode_i),
    .seg_ok_i (acc_seg_ok),
    .sel_i    (acc_entry.sel),
    .base_i   (acc_entry.base),
    .lim_i    (acc_entry.lim),
    .off_i    (acc_off_i),
    .size_i   (acc_size_i),
    .addr_o   (acc_addr),
    .fault_o  (acc_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_ok_o         <= 1'b0;
      ld_type_fault_o <= 1'b0;
      ld_np_fault_o   <= 1'b0;
      acc_valid_o     <= 1'b0;
      lim_fault_o     <= 1'b0;
      lin_addr_o      <= '0;
      acc_sel_o       <= '0;
      acc_rights_o    <= '0;
    end else begin
      ld_ok_o         <= ld_accept;
      ld_type_fault_o <= ld_valid_i && type_fault;
      ld_np_fault_o   <= ld_valid_i && np_fault;
      acc_valid_o     <= acc_valid_i && !acc_fault;
      lim_fault_o     <= acc_valid_i && acc_fault;
      if (acc_valid_i) begin
        lin_addr_o   <= acc_addr;
        acc_sel_o    <= acc_entry.sel;
        acc_rights_o <= acc_entry.rights;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_pkg::*;
#(
  parameter int unsigned NUM_SEG = 6,
  parameter int unsigned IDX_W   = $clog2(NUM_SEG)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prot_mode_i,
  input logic              ld_valid_i,
  input logic [IDX_W-1:0]  ld_seg_i,
  input logic [DESC_W-1:0] ld_desc_i,
  input logic              acc_valid_i,
  input logic              ld_ok_o,
  input logic              ld_type_fault_o,
  input logic              ld_np_fault_o,
  input logic              acc_valid_o,
  input logic              lim_fault_o
);
  AST_LD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_ok_o, ld_type_fault_o, ld_np_fault_o})); // R13
  AST_LD_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |=> (ld_ok_o || ld_type_fault_o || ld_np_fault_o)); // R13
  AST_LD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_i |=> !(ld_ok_o || ld_type_fault_o || ld_np_fault_o)); // R13
  AST_ACC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> (acc_valid_o ^ lim_fault_o)); // R5
  AST_ACC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> (!acc_valid_o && !lim_fault_o)); // R13
  AST_REAL_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && !prot_mode_i && int'(ld_seg_i) < NUM_SEG) |=> ld_ok_o); // R2
  AST_CS_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && prot_mode_i && ld_seg_i == IDX_W'(SEG_CS) && !ld_desc_i[43])
      |=> ld_type_fault_o); // R6
  AST_SS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && prot_mode_i && ld_seg_i == IDX_W'(SEG_SS) && ld_desc_i[43])
      |=> ld_type_fault_o); // R7
  AST_SYS_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && prot_mode_i && !ld_desc_i[44]) |=> ld_type_fault_o); // R8
  AST_NP_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && prot_mode_i && ld_desc_i[44] && !ld_desc_i[47]) |=> !ld_ok_o); // R9
endmodule

bind seg_xlate seg_xlate_chk #(.NUM_SEG(NUM_SEG)) u_chk (.*);

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prot_mode_i = 1'b0;
  logic        ld_valid_i = 1'b0;
  logic [2:0]  ld_seg_i = '0;
  logic [15:0] ld_sel_i = '0;
  logic [63:0] ld_desc_i = '0;
  logic        acc_valid_i = 1'b0;
  logic [2:0]  acc_seg_i = '0;
  logic [31:0] acc_off_i = '0;
  logic [1:0]  acc_size_i = '0;
  logic        ld_ok_o, ld_type_fault_o, ld_np_fault_o;
  logic        acc_valid_o, lim_fault_o;
  logic [31:0] lin_addr_o;
  logic [15:0] acc_sel_o;
  logic [11:0] acc_rights_o;

  seg_xlate u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_sel    [6];
  logic [31:0] m_base   [6];
  logic [31:0] m_lim    [6];
  logic [11:0] m_rights [6];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
      input bit g, p, input logic [1:0] dpl, input bit s, x, rw);
    return {base[31:24], g, 1'b1, 1'b0, 1'b0, lim[19:16], p, dpl, s, x, 1'b0, rw, 1'b0,
            base[23:0], lim[15:0]};
  endfunction

  function automatic logic [31:0] exp_lim(input logic [63:0] d);
    logic [19:0] l = {d[51:48], d[15:0]};
    return d[55] ? {l, 12'hFFF} : {12'h000, l};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 6; i++) begin
      m_sel[i] = '0; m_base[i] = '0; m_lim[i] = 32'hFFFF; m_rights[i] = 12'h092;
    end
  endtask

  // one request cycle: drive at negedge, check at next negedge
  task automatic step(input bit pm, ldv, input logic [2:0] ls, input logic [15:0] lsel,
      input logic [63:0] ld, input bit accv, input logic [2:0] as, input logic [31:0] ao,
      input logic [1:0] asz, input string tag);
    bit tf, np, ok, a_flt, a_val;
    logic [32:0] last;
    logic [31:0] a_addr;
    logic [15:0] a_sel;
    logic [11:0] a_rt;
    string lt, at;
    prot_mode_i = pm; ld_valid_i = ldv; ld_seg_i = ls; ld_sel_i = lsel; ld_desc_i = ld;
    acc_valid_i = accv; acc_seg_i = as; acc_off_i = ao; acc_size_i = asz;
    tf = 0; np = 0; ok = 0; lt = "R2";
    if (ldv) begin
      if (ls >= 6)                 begin tf = 1; lt = "R10"; end
      else if (pm && !ld[44])      begin tf = 1; lt = "R8"; end
      else if (pm && ls == 1 && !ld[43]) begin tf = 1; lt = "R6"; end
      else if (pm && ls == 2 && ld[43])  begin tf = 1; lt = "R7"; end
      else if (pm && !ld[47])      begin np = 1; lt = "R9"; end
      else begin ok = 1; lt = pm ? "R4" : "R2"; end
    end
    a_flt = 0; a_val = 0; a_addr = '0; a_sel = '0; a_rt = '0; at = pm ? "R4" : "R3";
    if (accv) begin
      last = {1'b0, ao} + 33'(asz);
      if (as >= 6) begin a_flt = 1; at = "R10"; end
      else begin
        a_sel = m_sel[as]; a_rt = m_rights[as];
        if (pm) begin
          a_flt = last > {1'b0, m_lim[as]}; a_addr = m_base[as] + ao;
          if (a_flt) at = "R5";
        end else begin
          a_flt = last > 33'h0FFFF; a_addr = {12'h000, m_sel[as], 4'h0} + ao;
        end
      end
      a_val = !a_flt;
    end
    if (tag != "") begin lt = tag; at = tag; end
    @(posedge clk_i);
    @(negedge clk_i);
    chk({ld_ok_o, ld_type_fault_o, ld_np_fault_o} === {ok, tf, np}, lt,
        64'({ld_ok_o, ld_type_fault_o, ld_np_fault_o}), 64'({ok, tf, np}));
    chk({acc_valid_o, lim_fault_o} === {a_val, a_flt}, at,
        64'({acc_valid_o, lim_fault_o}), 64'({a_val, a_flt}));
    if (a_val) begin
      chk(lin_addr_o === a_addr, at, 64'(lin_addr_o), 64'(a_addr));
      chk(acc_sel_o === a_sel, "R11", 64'(acc_sel_o), 64'(a_sel));
      chk(acc_rights_o === a_rt, "R11", 64'(acc_rights_o), 64'(a_rt));
    end
    if (ok) begin
      m_sel[ls] = lsel;
      if (pm) begin
        m_base[ls] = {ld[63:56], ld[39:16]}; m_lim[ls] = exp_lim(ld);
        m_rights[ls] = {ld[55:52], ld[47:40]};
      end else begin
        m_base[ls] = {12'h000, lsel, 4'h0}; m_lim[ls] = 32'hFFFF; m_rights[ls] = 12'h092;
      end
    end
  endtask

  task automatic acc(input bit pm, input logic [2:0] s, input logic [31:0] o,
      input logic [1:0] z, input string tag);
    step(pm, 0, 0, 0, 0, 1, s, o, z, tag);
  endtask

  task automatic load(input bit pm, input logic [2:0] s, input logic [15:0] sel,
      input logic [63:0] d, input string tag);
    step(pm, 1, s, sel, d, 0, 0, 0, 0, tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] d;
    void'($urandom(32'd4242));
    model_reset();
    #(CLK_PERIOD * 2 + CLK_PERIOD / 2);
    // R1 reset state
    chk({ld_ok_o, ld_type_fault_o, ld_np_fault_o, acc_valid_o, lim_fault_o} === 5'b0, "R1",
        64'({ld_ok_o, ld_type_fault_o, ld_np_fault_o, acc_valid_o, lim_fault_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    acc(1, 1, 32'hFFFF, 0, "R1");
    acc(1, 3, 32'hFFFE, 3, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R13");

    // real mode
    load(0, 3, 16'h1234, 64'hDEAD_BEEF_0000_0000, "R2");
    acc(0, 3, 32'h10, 1, "R3");
    acc(0, 3, 32'hFFFF, 1, "R3");
    acc(0, 3, 32'hFFFC, 3, "R3");
    load(0, 1, 16'hF000, '0, "R2");
    acc(1, 1, 32'h0, 0, "R11");

    // protected mode
    load(1, 1, 16'h0008, mk_desc(32'h1234_5678, 20'h00FFF, 0, 1, 2'd0, 1, 1, 1), "R4");
    acc(1, 1, 32'hFFF, 0, "R4");
    acc(1, 1, 32'hFFE, 1, "R5");
    acc(1, 1, 32'hFFF, 1, "R5");
    load(1, 3, 16'h0010, mk_desc(32'h0010_0000, 20'h00001, 1, 1, 2'd3, 1, 0, 1), "R5");
    acc(1, 3, 32'h1FFC, 3, "R5");
    acc(1, 3, 32'h1FFD, 3, "R5");
    load(1, 4, 16'h0018, mk_desc(32'hF000_0000, 20'hFFFFF, 1, 1, 2'd1, 1, 0, 1), "R5");
    acc(1, 4, 32'hFFFF_FFFF, 0, "R4");
    acc(1, 4, 32'hFFFF_FFFF, 1, "R5");

    // rejected loads leave the cache alone
    load(1, 1, 16'h0020, mk_desc(32'hAAAA_0000, 20'hFFFFF, 1, 1, 2'd0, 1, 0, 1), "R6");
    acc(1, 1, 32'h100, 0, "R10");
    load(1, 2, 16'h0028, mk_desc(32'hBBBB_0000, 20'hFFFFF, 1, 1, 2'd0, 1, 1, 1), "R7");
    acc(1, 2, 32'h100, 0, "R10");
    load(1, 3, 16'h0030, mk_desc(32'hCCCC_0000, 20'hFFFFF, 1, 1, 2'd0, 0, 0, 1), "R8");
    load(1, 3, 16'h0038, mk_desc(32'hDDDD_0000, 20'hFFFFF, 1, 0, 2'd0, 1, 0, 1), "R9");
    acc(1, 3, 32'h100, 0, "R9");
    load(1, 2, 16'h0040, mk_desc(32'hEEEE_0000, 20'hFFFFF, 1, 0, 2'd0, 1, 1, 1), "R9");
    load(1, 6, 16'h0048, mk_desc(32'h0, 20'hFFFFF, 1, 1, 2'd0, 1, 0, 1), "R10");
    acc(1, 7, 32'h0, 0, "R10");
    acc(0, 6, 32'h0, 0, "R10");

    // same-cycle load and access
    step(1, 1, 5, 16'h0050, mk_desc(32'h0300_0000, 20'h00010, 0, 1, 2'd2, 1, 0, 1),
         1, 5, 32'h20, 0, "R12");
    acc(1, 5, 32'h10, 0, "R12");
    acc(1, 5, 32'h11, 0, "R12");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R13");

    // random mix
    for (int n = 0; n < 600; n++) begin
      bit pm = ($urandom % 4) != 0;
      logic [2:0] ls = 3'($urandom % 7);
      logic [2:0] as = 3'($urandom % 7);
      logic [31:0] ao;
      d = mk_desc($urandom, 20'($urandom), 1'($urandom), ($urandom % 8) != 0, 2'($urandom),
                  ($urandom % 8) != 0, 1'($urandom), 1'($urandom));
      if (as < 6 && ($urandom % 2)) ao = (pm ? m_lim[as] : 32'hFFFF) - ($urandom % 5);
      else ao = $urandom & 32'h1_FFFF;
      step(pm, ($urandom % 3) != 0, ls, 16'($urandom), d, ($urandom % 4) != 0, as, ao,
           2'($urandom), "");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R13");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule